// File: doc/BRIEF.md
# Byte-Programmed Multiply / Divide / Accumulate Engine

This block gives a byte-wide host a small arithmetic engine. The host loads two 16-bit operands one byte at a time, picks an operation in a control byte, and starts that operation by writing the high byte of the second operand. The engine can multiply, divide, or add the product into a 40-bit running sum. The result is read back one byte at a time through a byte selector, and a sticky flag reports when the running sum has overflowed.

Multiply and the accumulated product treat both operands as two's-complement values. Divide takes a signed dividend and an unsigned divisor. It returns the quotient in the low half-word and the remainder in the next half-word of the result. The quotient is computed one bit per cycle. While that runs, a busy output is high, and all register writes are dropped.

Top module: `mdac_unit`

## Requirements
- R1: After reset the result reads as zero, `overflow` and `busy` are low, both operands are zero, and the selected operation is multiply (code 0).
- R2: Write addresses: 0 is control, 1 is operand A low byte, 2 is A high byte, 3 is operand B low byte, 4 is B high byte. Writes to addresses 5 to 7 change nothing. `rd_sel` k (0 to 4) returns result bits 8k+7:8k, and selections 5 to 7 read zero.
- R3: Only a write to address 4 starts an operation. Writes to addresses 0 to 3 leave the result unchanged, except for the clear command of R9.
- R4: Operation code 0 (control bits 1:0) places the signed product A×B, sign-extended to 40 bits, in the result one cycle after the trigger write, without raising `busy`.
- R5: Operation code 1 divides signed A by unsigned B. The quotient is truncated toward zero and placed in bits 15:0. The remainder takes the sign of A and is placed in bits 31:16. Bits 39:32 are zero.
- R6: A divide with B equal to zero yields A in result bits 31:16 and zeros elsewhere, one cycle after the trigger, without raising `busy`.
- R7: A divide with a nonzero divisor holds `busy` high for exactly 17 cycles, starting the cycle after the trigger. The result is final when `busy` falls.
- R8: Every register write made while `busy` is high is ignored, including triggers.
- R9: A control write with bit 1 set clears the result and `overflow`. A control write with bit 1 clear changes only the operation and keeps the result.
- R10: Operation codes 2 and 3 add the signed product to the 40-bit running sum held in the result, wrapping modulo 2^40.
- R11: `overflow` is set when an accumulate step overflows as a signed 40-bit addition. It then stays set until a clear command or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 3 | Result byte selector |
| rd_data | output | 8 | Selected result byte |
| busy | output | 1 | Divide in progress; writes ignored |
| overflow | output | 1 | Sticky accumulate overflow flag |

## Verification
Faults inside this block show at the ports quickly. A wrong operand byte or a wrong operation latch shows up in the result bytes one cycle after the next trigger. A wrong divider step or a wrong sign fix-up shows up as wrong quotient or remainder bytes when `busy` falls, 17 cycles after the trigger. A wrong iteration count shows up in the length of the `busy` pulse. A lost sticky bit or a missed signed-overflow detect shows up on `overflow` only at the accumulate step that crosses 2^39, or on the step after it. For that reason the accumulator is driven all the way across that boundary. Sweeping operand grids that include the extreme signed values makes wrong sign handling visible in the upper result bytes.

// File: rtl/mdac_pkg.sv
package mdac_pkg;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_DIV  = 2'd1,
        OP_ACC  = 2'd2,
        OP_ACC3 = 2'd3
    } op_e;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_ALO  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_AHI  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_BLO  = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_BHI  = 3'd4;

endpackage

// File: rtl/mdac_regs.sv
module mdac_regs
    import mdac_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OP_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              busy_i,
    output op_e               mode_o,
    output logic [OP_W-1:0]   a_o,
    output logic [OP_W-1:0]   b_next_o,
    output logic              trig_o,
    output logic              clr_o
);

    typedef struct packed {
        op_e             mode;
        logic [OP_W-1:0] a;
        logic [OP_W-1:0] b;
    } regs_t;

    regs_t s_d, s_q;
    logic  accept;

    always_comb begin
        s_d    = s_q;
        trig_o = 1'b0;
        clr_o  = 1'b0;
        accept = wr_en && !busy_i;
        if (accept) begin
            case (wr_addr)
                ADR_CTRL: begin
                    s_d.mode = op_e'(wr_data[1:0]);
                    clr_o    = wr_data[1];
                end
                ADR_ALO: s_d.a[BYTE_W-1:0]    = wr_data;
                ADR_AHI: s_d.a[OP_W-1:BYTE_W] = wr_data;
                ADR_BLO: s_d.b[BYTE_W-1:0]    = wr_data;
                ADR_BHI: begin
                    s_d.b[OP_W-1:BYTE_W] = wr_data;
                    trig_o               = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: OP_MUL, a: '0, b: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o   = s_q.mode;
    assign a_o      = s_q.a;
    assign b_next_o = s_d.b;

    // R8
    writes_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && wr_en) |=> ($stable(s_q.a) && $stable(s_q.b) && $stable(s_q.mode)));

endmodule

// File: rtl/mdac_divider.sv
module mdac_divider #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);

    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     quo;
        logic [W-1:0]     rem;
        logic [W-1:0]     dvs;
    } div_t;

    div_t       s_d, s_q;
    logic [W:0] shifted;
    logic [W:0] diff;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        shifted  = {s_q.rem, s_q.quo[W-1]};
        diff     = shifted - {1'b0, s_q.dvs};
        if (start_i && !s_q.busy) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_FULL;
            s_d.quo  = dividend_i;
            s_d.rem  = '0;
            s_d.dvs  = divisor_i;
        end else if (s_q.busy) begin
            if (shifted >= {1'b0, s_q.dvs}) begin
                s_d.rem = diff[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b1};
            end else begin
                s_d.rem = shifted[W-1:0];
                s_d.quo = {s_q.quo[W-2:0], 1'b0};
            end
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy = 1'b0;
                s_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.done;
    assign quo_o  = s_q.quo;
    assign rem_o  = s_q.rem;

    // R7
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.cnt != '0));

    // R7
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({s_q.busy, s_q.done}));

    // R7
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.done) |-> $past(s_q.busy));

endmodule

// File: rtl/mdac_mac.sv
module mdac_mac #(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  logic [OP_W-1:0]  a_i,
    input  logic [OP_W-1:0]  b_i,
    input  logic [ACC_W-1:0] acc_i,
    output logic [ACC_W-1:0] prod_o,
    output logic [ACC_W-1:0] sum_o,
    output logic             ovf_o
);

    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic signed [PROD_W-1:0] prod;

    always_comb begin
        prod   = $signed(a_i) * $signed(b_i);
        prod_o = {{EXT_W{prod[PROD_W-1]}}, prod};
        sum_o  = acc_i + prod_o;
        ovf_o  = (acc_i[ACC_W-1] == prod_o[ACC_W-1]) &&
                 (sum_o[ACC_W-1] != acc_i[ACC_W-1]);
    end

endmodule

// File: rtl/mdac_unit.sv
module mdac_unit
    import mdac_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int OP_W   = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [2:0]        rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              busy,
    output logic              overflow
);

    localparam int RES_BYTES = ACC_W / BYTE_W;
    localparam int TOP_W     = ACC_W - 2 * OP_W;

    typedef struct packed {
        logic [ACC_W-1:0] result;
        logic             ovf;
        logic             neg;
    } unit_t;

    unit_t s_d, s_q;

    op_e              mode;
    logic [OP_W-1:0]  op_a;
    logic [OP_W-1:0]  op_b;
    logic             trig;
    logic             clr;
    logic             div_busy;
    logic             div_done;
    logic             div_start;
    logic [OP_W-1:0]  div_quo;
    logic [OP_W-1:0]  div_rem;
    logic [OP_W-1:0]  a_mag;
    logic [OP_W-1:0]  quo_fix;
    logic [OP_W-1:0]  rem_fix;
    logic [ACC_W-1:0] prod;
    logic [ACC_W-1:0] sum;
    logic             add_ovf;

    assign busy = div_busy | div_done;

    mdac_regs #(.BYTE_W(BYTE_W), .OP_W(OP_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy_i  (busy),
        .mode_o  (mode),
        .a_o     (op_a),
        .b_next_o(op_b),
        .trig_o  (trig),
        .clr_o   (clr)
    );

    mdac_mac #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mac (
        .a_i   (op_a),
        .b_i   (op_b),
        .acc_i (s_q.result),
        .prod_o(prod),
        .sum_o (sum),
        .ovf_o (add_ovf)
    );

    assign a_mag     = op_a[OP_W-1] ? (~op_a + 1'b1) : op_a;
    assign div_start = trig && (mode == OP_DIV) && (op_b != '0);

    mdac_divider #(.W(OP_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (div_start),
        .dividend_i(a_mag),
        .divisor_i (op_b),
        .busy_o    (div_busy),
        .done_o    (div_done),
        .quo_o     (div_quo),
        .rem_o     (div_rem)
    );

    always_comb begin
        s_d     = s_q;
        quo_fix = s_q.neg ? (~div_quo + 1'b1) : div_quo;
        rem_fix = s_q.neg ? (~div_rem + 1'b1) : div_rem;
        if (clr) begin
            s_d.result = '0;
            s_d.ovf    = 1'b0;
        end else if (div_done) begin
            s_d.result = {{TOP_W{1'b0}}, rem_fix, quo_fix};
        end else if (trig) begin
            case (mode)
                OP_MUL: s_d.result = prod;
                OP_DIV: begin
                    s_d.neg = op_a[OP_W-1];
                    if (op_b == '0) begin
                        s_d.result = {{TOP_W{1'b0}}, op_a, {OP_W{1'b0}}};
                    end
                end
                default: begin
                    s_d.result = sum;
                    s_d.ovf    = s_q.ovf | add_ovf;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < RES_BYTES; k++) begin
            if (rd_sel == 3'(k)) begin
                rd_data = s_q.result[k*BYTE_W +: BYTE_W];
            end
        end
    end

    assign overflow = s_q.ovf;

    // R9
    clear_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (s_q.result == '0 && !overflow));

    // R11
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clr) |=> overflow);

    // R6
    div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == OP_DIV && op_b == '0) |=> (!busy && s_q.result[OP_W-1:0] == '0));

    // R4
    mul_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && mode == OP_MUL) |=> !busy);

    // R7
    div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_start |=> div_busy);

endmodule

// File: tb/mdac_unit_bench.sv
`timescale 1ns/1ps
module mdac_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_sel = '0;
    logic [7:0] rd_data;
    logic       busy;
    logic       overflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mdac_unit u_mdac_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .busy(busy), .overflow(overflow)
    );

    task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic get_res(output logic [39:0] r);
        for (int k = 0; k < 5; k++) begin
            rd_sel = 3'(k);
            #0.1;
            r[k*8 +: 8] = rd_data;
        end
    endtask

    task automatic load(input logic [15:0] a, input logic [15:0] b);
        wr(3'd1, a[7:0]); wr(3'd2, a[15:8]); wr(3'd3, b[7:0]); wr(3'd4, b[15:8]);
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic logic [39:0] exp_mul(input logic [15:0] a, input logic [15:0] b);
        longint p;
        p = longint'($signed(a)) * longint'($signed(b));
        return p[39:0];
    endfunction

    function automatic logic [39:0] exp_div(input logic [15:0] a, input logic [15:0] b);
        int sa, ub, q, r;
        sa = int'($signed(a));
        ub = int'(b);
        if (ub == 0) return {8'h00, a, 16'h0000};
        q = sa / ub;
        r = sa % ub;
        return {8'h00, r[15:0], q[15:0]};
    endfunction

    logic [15:0] vals [10] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h0002, 16'h7FFF,
                               16'h8000, 16'h007B, 16'hFFB3, 16'h1234, 16'hC001};
    logic [15:0] dvs  [8]  = '{16'h0001, 16'h0002, 16'h0003, 16'h0007,
                               16'hFFFF, 16'h8000, 16'h00FF, 16'h03E8};

    initial begin
        #(4 * 190000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [39:0] r;
        logic [39:0] e;
        longint acc;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        get_res(r);
        chk("R1 result", r, 40'h0);
        chk("R1 flags", {38'h0, busy, overflow}, 40'h0);
        wr(3'd4, 8'h00);
        get_res(r);
        chk("R1 mode mul with zero operands", r, 40'h0);

        // R4 multiply sweep
        wr(3'd0, 8'h00);
        foreach (vals[i]) begin
            foreach (vals[j]) begin
                load(vals[i], vals[j]);
                chk("R4 busy", {39'h0, busy}, 40'h0);
                get_res(r);
                chk("R4 product", r, exp_mul(vals[i], vals[j]));
            end
        end

        // R2 read selector beyond result bytes, R3 non-trigger writes
        load(16'h7FFF, 16'h7FFF);
        wr(3'd1, 8'h55); wr(3'd2, 8'hAA); wr(3'd3, 8'h11); wr(3'd0, 8'h01);
        get_res(r);
        chk("R3 result held", r, exp_mul(16'h7FFF, 16'h7FFF));
        chk("R9 mode write without clear", r, exp_mul(16'h7FFF, 16'h7FFF));
        for (int k = 5; k < 8; k++) begin
            rd_sel = 3'(k);
            #0.1;
            chk("R2 unused read", {32'h0, rd_data}, 40'h0);
        end
        wr(3'd0, 8'h00);
        load(16'h0102, 16'h0304);
        wr(3'd5, 8'hFF); wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        wr(3'd4, 8'h03);
        get_res(r);
        chk("R2 unused addresses no effect", r, exp_mul(16'h0102, 16'h0304));

        // R5 R7 divide sweep
        wr(3'd0, 8'h01);
        foreach (vals[i]) begin
            foreach (dvs[j]) begin
                load(vals[i], dvs[j]);
                wait_idle(n);
                chk("R7 busy length", 40'(n), 40'd17);
                get_res(r);
                chk("R5 quotient remainder", r, exp_div(vals[i], dvs[j]));
            end
        end

        // R6 divide by zero
        foreach (vals[i]) begin
            load(vals[i], 16'h0000);
            chk("R6 no busy", {39'h0, busy}, 40'h0);
            get_res(r);
            chk("R6 result", r, exp_div(vals[i], 16'h0000));
        end

        // R8 writes ignored while busy
        load(16'hF000, 16'h0007);
        wr(3'd1, 8'h99);
        wr(3'd4, 8'h00);
        wr(3'd0, 8'h02);
        wait_idle(n);
        get_res(r);
        chk("R8 divide unaffected", r, exp_div(16'hF000, 16'h0007));
        wr(3'd4, 8'h00);
        wait_idle(n);
        get_res(r);
        chk("R8 operands and mode kept", r, exp_div(16'hF000, 16'h0007));

        // R9 R10 accumulate, code 2 then code 3
        for (int m = 2; m < 4; m++) begin
            wr(3'd0, 8'(m));
            get_res(r);
            chk("R9 clear", r, 40'h0);
            acc = 0;
            foreach (vals[i]) begin
                load(vals[i], vals[9 - i]);
                acc = acc + longint'($signed(vals[i])) * longint'($signed(vals[9 - i]));
                get_res(r);
                e = acc[39:0];
                chk("R10 running sum", r, e);
            end
        end

        // R11 overflow at 2^39
        wr(3'd0, 8'h02);
        load(16'h8000, 16'h8000);
        for (int k = 1; k < 511; k++) wr(3'd4, 8'h80);
        get_res(r);
        chk("R11 below limit value", r, 40'h7F_C000_0000);
        chk("R11 below limit flag", {39'h0, overflow}, 40'h0);
        wr(3'd4, 8'h80);
        get_res(r);
        chk("R11 wrapped sum", r, 40'h80_0000_0000);
        chk("R11 flag set", {39'h0, overflow}, 40'h1);
        load(16'h0000, 16'h0000);
        chk("R11 flag sticky", {39'h0, overflow}, 40'h1);
        wr(3'd0, 8'h00);
        chk("R11 kept by mode write", {39'h0, overflow}, 40'h1);
        wr(3'd0, 8'h02);
        get_res(r);
        chk("R9 clear result", r, 40'h0);
        chk("R11 cleared", {39'h0, overflow}, 40'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule